// File: doc/BRIEF.md
# Serial Configuration Port with Cycle Abort

This block is a slave serial control port that holds a small register file. A host selects it with an active-low chip select, clocks bits in on a serial clock, and opens every transfer with one instruction byte. That byte carries the transfer direction, the number of data bytes, and a starting register address. The data bytes follow, most significant bit first. After each byte the address steps down by one.

One register bit picks the wiring of the read path. When the bit is clear, the shared data line carries read data back to the host. When it is set, the shared line becomes an input only, and read data leaves on a dedicated output instead. A synchronous abort input returns the sequencer to the instruction phase and releases both outputs, and it does not alter any stored byte. Chip select acts as a second way back to the instruction phase.

All inputs are sampled on the system clock `clk`, and serial clock edges are found by comparing the serial clock with its value one cycle earlier. The pad drivers lie outside the block, so the shared line appears as a separate input, output and output enable.

Top module: `serial_cfg_port`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every stored byte is zero and both `sdio_oe` and `sdo_oe` are low.
- R2: Bits are taken from `sdio_i` on rising edges of `sclk`, most significant bit first. In the first byte after selection, bit 7 set means read and clear means write, bits 6:5 hold the data byte count minus one, and bits 4:0 hold the start address.
- R3: In a write, each complete data byte is stored at the current address. The address then decreases by one and wraps from 0 to 31.
- R4: In a read, the output bit changes only on falling edges of `sclk`. The most significant bit of the addressed byte appears on the first falling edge after the instruction's last bit. Further bytes come from addresses that decrease by one.
- R5: After the last data byte of a transfer, the next byte clocked in under the same chip select is a new instruction.
- R6: Raising `cs_n` discards any partially shifted byte, leaves the register file unchanged, and makes the next byte an instruction.
- R7: A high `sync_abort` returns the port to the instruction phase and drops both output enables on the next cycle. The register file is not changed.
- R8: Bit 7 of register 0x00 selects the read path. When it is 0, read data is driven on `sdio_o` with `sdio_oe` and `sdo_oe` stays low. When it is 1, read data is driven on `sdo_o` with `sdo_oe` and `sdio_oe` stays low.
- R9: The output enables come from registers, are never high together, and are low on the cycle after `cs_n` is seen high.
- R10: `regs_o` shows stored byte k at bits 8k+7 down to 8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdio_i | input | 1 | Value seen on the shared data line |
| sync_abort | input | 1 | Aborts the cycle in progress, active high |
| sdio_o | output | 1 | Read data for the shared line |
| sdio_oe | output | 1 | Drive enable for the shared line |
| sdo_o | output | 1 | Read data for the dedicated output |
| sdo_oe | output | 1 | Drive enable for the dedicated output; low means high impedance |
| regs_o | output | 256 | Contents of the whole register file |

## Verification
The properties assume that `cs_n`, `sclk`, `sdio_i` and `sync_abort` are synchronous to `clk`. They also assume that each level of `sclk` lasts at least one `clk` cycle, so that no serial edge is lost. Under these assumptions, the absence of a write while `cs_n` or `sync_abort` is high, and the release of the enables one cycle later, follow from the sampled levels alone. The stimulus changes every input on the falling edge of `clk` and holds each `sclk` level for at least two cycles. It changes `sdio_i` only while `sclk` is low and pulses the abort between serial bits, so the assumptions are always met.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cs_n,
  input  logic                              sclk,
  input  logic                              sdio_i,
  input  logic                              sync_abort,
  output logic                              sdio_o,
  output logic                              sdio_oe,
  output logic                              sdo_o,
  output logic                              sdo_oe,
  output logic [(1<<ADDR_W)*DATA_W-1:0]     regs_o
);
  localparam int NREG  = 1 << ADDR_W;
  localparam int CNT_W = DATA_W - 1 - ADDR_W;
  localparam int BIT_W = $clog2(DATA_W);

  typedef enum logic [1:0] {PH_INS, PH_WR, PH_RD} phase_t;

  phase_t             phase_q;
  logic               sclk_q;
  logic [BIT_W-1:0]   bit_q;
  logic [DATA_W-1:0]  rx_q, tx_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [CNT_W-1:0]   left_q;
  logic               out_q, drive_q;
  logic [DATA_W-1:0]  regs_q [NREG];

  wire rise  = sclk & ~sclk_q;
  wire fall  = ~sclk & sclk_q;
  wire quiet = cs_n | sync_abort;
  wire [DATA_W-1:0] byte_in   = {rx_q[DATA_W-2:0], sdio_i};
  wire              byte_done = rise && (bit_q == BIT_W'(DATA_W-1));
  wire [ADDR_W-1:0] ins_addr  = byte_in[ADDR_W-1:0];
  wire [ADDR_W-1:0] addr_nx   = addr_q - ADDR_W'(1);
  wire              in_only   = regs_q[0][DATA_W-1];
  wire              last_byte = (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_INS;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      out_q   <= 1'b0;
      drive_q <= 1'b0;
    end else if (quiet) begin
      phase_q <= PH_INS;
      bit_q   <= '0;
      drive_q <= 1'b0;
    end else begin
      if (rise) begin
        rx_q  <= byte_in;
        bit_q <= byte_done ? '0 : bit_q + BIT_W'(1);
      end
      if (byte_done) begin
        case (phase_q)
          PH_INS: begin
            addr_q  <= ins_addr;
            left_q  <= byte_in[DATA_W-2 -: CNT_W];
            tx_q    <= regs_q[ins_addr];
            phase_q <= byte_in[DATA_W-1] ? PH_RD : PH_WR;
          end
          PH_WR: begin
            addr_q <= addr_nx;
            left_q <= left_q - CNT_W'(1);
            if (last_byte) phase_q <= PH_INS;
          end
          default: begin
            addr_q <= addr_nx;
            left_q <= left_q - CNT_W'(1);
            tx_q   <= regs_q[addr_nx];
            if (last_byte) phase_q <= PH_INS;
          end
        endcase
      end
      if (fall && phase_q == PH_RD) begin
        out_q   <= tx_q[DATA_W-1];
        tx_q    <= {tx_q[DATA_W-2:0], 1'b0};
        drive_q <= 1'b1;
      end else if (phase_q != PH_RD) begin
        drive_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (!quiet && byte_done && phase_q == PH_WR) begin
      regs_q[addr_q] <= byte_in;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_view
    assign regs_o[g*DATA_W +: DATA_W] = regs_q[g];
  end

  assign sdio_o  = out_q;
  assign sdo_o   = out_q;
  assign sdio_oe = drive_q & ~in_only;
  assign sdo_oe  = drive_q & in_only;

  assert_release_on_deselect_R9: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !sdio_oe && !sdo_oe);
  assert_deselect_keeps_regs_R6: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(regs_o));
  assert_abort_releases_R7: assert property (@(posedge clk) disable iff (rst)
    sync_abort |=> !sdio_oe && !sdo_oe);
  assert_abort_keeps_regs_R7: assert property (@(posedge clk) disable iff (rst)
    sync_abort |=> $stable(regs_o));
  assert_drive_needs_select_R4: assert property (@(posedge clk) disable iff (rst)
    (sdio_oe || sdo_oe) |-> $past(!cs_n));
endmodule

// File: tb/serial_cfg_port_bench.sv
module serial_cfg_port_bench;
  logic clk = 1'b0;
  logic rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdio_i = 1'b0, sync_abort = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic [255:0] regs_o;
  int checks = 0, fails = 0, cyc = 0;
  logic seen_sdio = 1'b0, seen_sdo = 1'b0;

  always #5 clk = ~clk;

  serial_cfg_port u_serial_cfg_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
    .sync_abort(sync_abort), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe), .regs_o(regs_o));

  task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rb(input int a);
    return regs_o[a*8 +: 8];
  endfunction

  // behavioural reference model
  int m_regs [32];
  int m_phase = 0, m_bit = 0, m_rx = 0, m_tx = 0, m_addr = 0, m_left = 0;
  logic m_ps = 1'b0, m_out = 1'b0, m_drive = 1'b0;

  always @(posedge clk) begin
    logic r, f;
    int p0, b;
    logic [255:0] mexp;
    r = sclk && !m_ps;
    f = !sclk && m_ps;
    m_ps = sclk;
    p0 = m_phase;
    if (rst) begin
      for (int i = 0; i < 32; i++) m_regs[i] = 0;
      m_phase = 0; m_bit = 0; m_rx = 0; m_tx = 0; m_addr = 0; m_left = 0;
      m_ps = 1'b0; m_out = 1'b0; m_drive = 1'b0;
    end else if (cs_n || sync_abort) begin
      m_phase = 0; m_bit = 0; m_drive = 1'b0;
    end else begin
      if (r) begin
        b = ((m_rx << 1) | int'(sdio_i)) & 255;
        m_rx = b;
        if (m_bit == 7) begin
          m_bit = 0;
          if (p0 == 0) begin
            m_addr = b & 31;
            m_left = (b >> 5) & 3;
            m_tx = m_regs[m_addr];
            m_phase = (b >= 128) ? 2 : 1;
          end else begin
            if (p0 == 1) m_regs[m_addr] = b;
            m_addr = (m_addr + 31) & 31;
            if (p0 == 2) m_tx = m_regs[m_addr];
            if (m_left == 0) m_phase = 0; else m_left--;
          end
        end else m_bit++;
      end
      if (f && p0 == 2) begin
        m_out = m_tx[7];
        m_tx = (m_tx << 1) & 255;
        m_drive = 1'b1;
      end else if (p0 != 2) m_drive = 1'b0;
    end
    #2;
    for (int i = 0; i < 32; i++) mexp[i*8 +: 8] = m_regs[i][7:0];
    chk("R3", "model register file", regs_o, mexp);
    chk("R9", "model sdio_oe", 256'(sdio_oe), 256'(m_drive & ~m_regs[0][7]));
    chk("R8", "model sdo_oe", 256'(sdo_oe), 256'(m_drive & m_regs[0][7]));
    if (m_drive) chk("R4", "model read bit", 256'(m_regs[0][7] ? sdo_o : sdio_o), 256'(m_out));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic sbit(input logic b, output logic got);
    @(negedge clk); sclk = 1'b0; sdio_i = b;
    @(negedge clk);
    if (sdio_oe) seen_sdio = 1'b1;
    if (sdo_oe) seen_sdo = 1'b1;
    got = sdo_oe ? sdo_o : sdio_o;
    @(negedge clk); sclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic sbyte(input logic [7:0] b, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) sbit(b[i], got[i]);
  endtask

  task automatic xfer(input logic [7:0] ins, input logic [31:0] wd, output logic [31:0] rd);
    logic [7:0] g;
    int n;
    n = int'(ins[6:5]) + 1;
    rd = '0;
    sbyte(ins, g);
    for (int k = 0; k < n; k++) begin
      sbyte(wd[31-8*k -: 8], g);
      rd[31-8*k -: 8] = g;
    end
  endtask

  task automatic sel(input logic v);
    @(negedge clk); cs_n = v;
  endtask

  task automatic pulse_abort();
    @(negedge clk); sync_abort = 1'b1;
    @(negedge clk); sync_abort = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    logic [7:0] g;
    logic bt;
    repeat (3) @(negedge clk);
    chk("R1", "regs in reset", regs_o, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "regs after reset", regs_o, '0);
    chk("R1", "enables after reset", 256'({sdio_oe, sdo_oe}), '0);

    sel(0); xfer(8'h04, 32'h5A00_0000, rd); sel(1);
    chk("R2", "single write addr 4", 256'(rb(4)), 256'(8'h5A));
    chk("R10", "byte 4 field of regs_o", 256'(regs_o[39:32]), 256'(8'h5A));

    sel(0); xfer(8'h4A, 32'h1122_3300, rd); sel(1);
    chk("R3", "addr 10", 256'(rb(10)), 256'(8'h11));
    chk("R3", "addr 9", 256'(rb(9)), 256'(8'h22));
    chk("R3", "addr 8", 256'(rb(8)), 256'(8'h33));

    sel(0); xfer(8'h20, 32'h1234_0000, rd); sel(1);
    chk("R3", "wrap start addr 0", 256'(rb(0)), 256'(8'h12));
    chk("R3", "wrap to addr 31", 256'(rb(31)), 256'(8'h34));

    seen_sdio = 1'b0; seen_sdo = 1'b0;
    sel(0); xfer(8'hCA, 32'h0, rd); sel(1);
    chk("R4", "three byte read", 256'(rd[31:8]), 256'(24'h112233));
    chk("R8", "bidirectional read used sdio", 256'({seen_sdio, seen_sdo}), 256'(2'b10));

    sel(0); xfer(8'h07, 32'h7700_0000, rd); xfer(8'h06, 32'h6600_0000, rd); sel(1);
    chk("R5", "first of two transfers", 256'(rb(7)), 256'(8'h77));
    chk("R5", "second under same select", 256'(rb(6)), 256'(8'h66));

    sel(0); sbyte(8'h05, g);
    for (int i = 0; i < 4; i++) sbit(1'b1, bt);
    sel(1);
    chk("R6", "partial byte discarded", 256'(rb(5)), 256'(8'h00));
    sel(0); xfer(8'h05, 32'h9900_0000, rd); sel(1);
    chk("R6", "instruction phase after deselect", 256'(rb(5)), 256'(8'h99));

    sel(0); sbyte(8'h03, g);
    for (int i = 0; i < 5; i++) sbit(1'b1, bt);
    pulse_abort();
    xfer(8'h03, 32'h3C00_0000, rd); sel(1);
    chk("R7", "write after abort", 256'(rb(3)), 256'(8'h3C));
    chk("R7", "neighbour untouched", 256'(rb(4)), 256'(8'h5A));

    sel(0); sbyte(8'h84, g);
    for (int i = 0; i < 4; i++) sbit(1'b0, bt);
    chk("R4", "read drives sdio", 256'(sdio_oe), 256'(1));
    @(negedge clk); sync_abort = 1'b1;
    @(negedge clk); sync_abort = 1'b0;
    chk("R7", "abort drops enables", 256'({sdio_oe, sdo_oe}), '0);
    sel(1);
    chk("R7", "abort keeps addr 4", 256'(rb(4)), 256'(8'h5A));

    sel(0); xfer(8'h00, 32'h8000_0000, rd); sel(1);
    chk("R8", "mode bit stored", 256'(rb(0)), 256'(8'h80));
    seen_sdio = 1'b0; seen_sdo = 1'b0;
    sel(0); xfer(8'h8A, 32'h0, rd); sel(1);
    chk("R8", "input-only read data", 256'(rd[31:24]), 256'(8'h11));
    chk("R8", "input-only read used sdo", 256'({seen_sdio, seen_sdo}), 256'(2'b01));

    sel(0); sbyte(8'h8A, g);
    for (int i = 0; i < 3; i++) sbit(1'b0, bt);
    chk("R9", "sdo enabled mid read", 256'({sdio_oe, sdo_oe}), 256'(2'b01));
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    chk("R9", "enables low after deselect", 256'({sdio_oe, sdo_oe}), '0);

    sel(0); xfer(8'h00, 32'h0, rd); sel(1);
    seen_sdio = 1'b0; seen_sdo = 1'b0;
    sel(0); xfer(8'h9F, 32'h0, rd); sel(1);
    chk("R4", "read addr 31", 256'(rd[31:24]), 256'(8'h34));
    chk("R8", "back to sdio", 256'({seen_sdio, seen_sdo}), 256'(2'b10));

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule